// File: doc/BRIEF.md
# Pipelined Fractional Complex Multiplier

This block multiplies two complex operands, X and Y. Each operand has a real part and an imaginary part, and each part is a 16-bit two's-complement fraction. The sign bit weighs -1 and bit 0 weighs 2^-15. Either operand can be conjugated before it reaches the multipliers.

Four signed multipliers form the partial products in parallel. Each product is kept as a 31-bit fraction, and a trap replaces the one product that cannot be represented. A following stage combines the products into a 32-bit real sum and a 32-bit imaginary sum, each with a sign weight of -2. A last stage can round the upper half of each sum and applies one shift, chosen by a 2-bit code, to both components.

The block accepts a new operation on every clock edge. Each operation is tagged by a valid flag, and its results appear three clocks after the input registers load.

Top module: `fxcmul`

## Requirements
- R1: While `rst_n` is sampled low, all pipeline registers clear. After reset, `out_valid` is low and both `out_re` and `out_im` read zero.
- R2: At a rising edge the X operand register loads `x_re`/`x_im` only when `x_load` is high, and the Y operand register loads `y_re`/`y_im` only when `y_load` is high. A register that does not load keeps its value and takes part in later operations.
- R3: The result is `out_re` = Xr·Yr − Xi·Yi and `out_im` = Xr·Yi + Xi·Yr. Each partial product is the 31-bit fraction (integer product scaled by 2^-30). Each sum is a 32-bit two's-complement value on the same scale.
- R4: A partial product whose two factors are both 16'h8000 (−1) becomes 31'h3FFF_FFFF, the most positive 31-bit fraction. No partial product ever equals 31'h4000_0000.
- R5: With `conj_x` high and `conj_y` low, the imaginary part of X is negated before multiplication.
- R6: With `conj_y` high and `conj_x` low, the imaginary part of Y is negated before multiplication.
- R7: With both `conj_x` and `conj_y` high, neither operand is conjugated.
- R8: Negating an imaginary part equal to 16'h8000 during conjugation gives 16'h7FFF.
- R9: With `round_en` high, bits 31:16 of each sum become bits 31:16 of (sum + 32'h0000_8000), wrapping modulo 2^32. Bits 15:0 pass unchanged. With `round_en` low, the sum passes unchanged.
- R10: `shift_sel` applies the same shift to both components after rounding. Code 00 applies no shift, 01 an arithmetic right shift by one, 10 a left shift by two and 11 a left shift by one. Bits shifted out are dropped, with no saturation.
- R11: The block accepts a new operation on every clock cycle. The control inputs `conj_x`, `conj_y`, `round_en` and `shift_sel` are sampled at the same edge as the operands and stay attached to that operation.
- R12: An operation starts at each edge where `x_load` or `y_load` is high. Its result appears with `out_valid` high after the third following edge. `out_valid` is low for every edge at which neither register loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_load | input | 1 | Load enable for the X operand register |
| y_load | input | 1 | Load enable for the Y operand register |
| x_re | input | 16 | Real part of X, signed fraction |
| x_im | input | 16 | Imaginary part of X, signed fraction |
| y_re | input | 16 | Real part of Y, signed fraction |
| y_im | input | 16 | Imaginary part of Y, signed fraction |
| conj_x | input | 1 | Conjugate X (negate its imaginary part) |
| conj_y | input | 1 | Conjugate Y (negate its imaginary part) |
| round_en | input | 1 | Round the upper half of each sum |
| shift_sel | input | 2 | Output shift code, shared by both components |
| out_valid | output | 1 | Result on `out_re`/`out_im` is valid |
| out_re | output | 32 | Real result |
| out_im | output | 32 | Imaginary result |

## Verification
An operation is driven on a falling edge, and its operands load at the next rising edge. The product, sum and output registers then fill on the three edges that follow, so the result is due at the falling edge four clock periods after the drive. The driver stamps each expected item with that due cycle. The monitor checks that `out_valid` rises exactly at the stamped cycle and never when no item is due, and only then compares the real and imaginary values.

// File: rtl/fxcmul_pkg.sv
// Package: shared types for the complex multiplier.
// Assumes: shift code values are fixed by the port contract (R10).
package fxcmul_pkg;

    // Output shift selection, shared by both result components
    typedef enum logic [1:0] {
        SH_NONE = 2'b00,
        SH_R1   = 2'b01,
        SH_L2   = 2'b10,
        SH_L1   = 2'b11
    } shift_e;

endpackage

// File: rtl/fxcmul_negsat.sv
// Module: fxcmul_negsat
// Conditionally negates a signed fraction. The one value whose negation
// does not fit (the most negative code) is clamped to the most positive code.
// Assumes: purely combinational, DW >= 2.
module fxcmul_negsat #(
    parameter int unsigned DW = 16
) (
    input  logic [DW-1:0] din,
    input  logic          neg,
    output logic [DW-1:0] dout
);
    localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MAXV = {1'b0, {(DW-1){1'b1}}};

    // Select pass-through, two's-complement negation or the clamp value
    always_comb begin
        if (!neg)
            dout = din;
        else if (din == MINV)
            dout = MAXV;
        else
            dout = (~din) + 1'b1;
    end
endmodule

// File: rtl/fxcmul_pmul.sv
// Module: fxcmul_pmul
// One registered fractional partial product. The signed DW x DW product
// drops its duplicate sign bit to give a (2*DW-1)-bit fraction. The single
// unrepresentable case (min * min) is trapped to the most positive value.
// Assumes: synchronous active-low reset, new operands every cycle.
module fxcmul_pmul #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [2*DW-2:0] p_q
);
    localparam int unsigned FW = 2 * DW;
    localparam int unsigned PW = 2 * DW - 1;
    localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};
    localparam logic [PW-1:0] PMAX = {1'b0, {(PW-1){1'b1}}};

    logic signed [FW-1:0] a_x;
    logic signed [FW-1:0] b_x;
    logic signed [FW-1:0] full;
    logic                 trap;
    logic [FW-1:0]        full_u;

    // Sign-extend both factors to the full product width
    always_comb begin
        a_x    = $signed({{DW{a[DW-1]}}, a});
        b_x    = $signed({{DW{b[DW-1]}}, b});
        full   = a_x * b_x;
        full_u = full;
        trap   = (a == MINV) && (b == MINV);
    end

    // Register the product, substituting the trap value when needed
    always_ff @(posedge clk) begin
        if (!rst_n)
            p_q <= '0;
        else if (trap)
            p_q <= PMAX;
        else
            p_q <= full_u[PW-1:0];
    end

    // The dropped top bit is only the duplicate sign
    logic unused_top;
    assign unused_top = full_u[FW-1];
endmodule

// File: rtl/fxcmul_post.sv
// Module: fxcmul_post
// Output conditioning for one sum: optional rounding of the upper half by
// adding one just below it (lower half kept), then the selected shift.
// Assumes: purely combinational; shifts drop bits and do not saturate.
module fxcmul_post
    import fxcmul_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic [2*DW-1:0] sum,
    input  logic            rnd,
    input  shift_e          shift,
    output logic [2*DW-1:0] res
);
    localparam int unsigned SW = 2 * DW;

    logic [DW-1:0]        upper;
    logic [SW-1:0]        rounded;
    logic signed [SW-1:0] rounded_s;

    // Round: carry from the bit below the kept half into the upper half
    always_comb begin
        upper     = sum[SW-1:DW] + (rnd ? {{(DW-1){1'b0}}, sum[DW-1]} : '0);
        rounded   = {upper, sum[DW-1:0]};
        rounded_s = $signed(rounded);
    end

    // Apply the one shared shift code
    always_comb begin
        case (shift)
            SH_R1:   res = rounded_s >>> 1;
            SH_L2:   res = {rounded[SW-3:0], 2'b00};
            SH_L1:   res = {rounded[SW-2:0], 1'b0};
            default: res = rounded;
        endcase
    end
endmodule

// File: rtl/fxcmul.sv
// Module: fxcmul (top)
// Pipelined complex fractional multiplier.
//   edge k  : operand registers load (per-port enables), controls sampled
//   edge k+1: four partial products registered (conjugation applied first)
//   edge k+2: real difference and imaginary sum registered
//   edge k+3: rounded and shifted results registered with out_valid
// Assumes: synchronous active-low reset; conj_x and conj_y both high
// means no conjugation.
module fxcmul
    import fxcmul_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            x_load,
    input  logic            y_load,
    input  logic [DW-1:0]   x_re,
    input  logic [DW-1:0]   x_im,
    input  logic [DW-1:0]   y_re,
    input  logic [DW-1:0]   y_im,
    input  logic            conj_x,
    input  logic            conj_y,
    input  logic            round_en,
    input  logic [1:0]      shift_sel,
    output logic            out_valid,
    output logic [2*DW-1:0] out_re,
    output logic [2*DW-1:0] out_im
);
    localparam int unsigned PW     = 2 * DW - 1;
    localparam int unsigned SW     = 2 * DW;
    localparam int unsigned NPROD  = 4;
    localparam int unsigned NSTAGE = 3;

    // Operand registers
    logic [DW-1:0] xr_q, xi_q, yr_q, yi_q;
    // Control pipeline (index 0 = operand stage, 2 = sum stage)
    logic          vld_p [NSTAGE];
    logic          rnd_p [NSTAGE];
    shift_e        sh_p  [NSTAGE];
    logic          cjx_q, cjy_q;

    // X operand register, loads only on its own enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xr_q <= '0;
            xi_q <= '0;
        end else if (x_load) begin
            xr_q <= x_re;
            xi_q <= x_im;
        end
    end

    // Y operand register, loads only on its own enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            yr_q <= '0;
            yi_q <= '0;
        end else if (y_load) begin
            yr_q <= y_re;
            yi_q <= y_im;
        end
    end

    // Controls travel with the operation through the pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cjx_q <= 1'b0;
            cjy_q <= 1'b0;
            for (int s = 0; s < NSTAGE; s++) begin
                vld_p[s] <= 1'b0;
                rnd_p[s] <= 1'b0;
                sh_p[s]  <= SH_NONE;
            end
        end else begin
            cjx_q    <= conj_x;
            cjy_q    <= conj_y;
            vld_p[0] <= x_load | y_load;
            rnd_p[0] <= round_en;
            sh_p[0]  <= shift_e'(shift_sel);
            for (int s = 1; s < NSTAGE; s++) begin
                vld_p[s] <= vld_p[s-1];
                rnd_p[s] <= rnd_p[s-1];
                sh_p[s]  <= sh_p[s-1];
            end
        end
    end

    // Conjugation: exactly one control high negates that imaginary part
    logic          negx, negy;
    logic [DW-1:0] xi_c, yi_c;

    assign negx = cjx_q & ~cjy_q;
    assign negy = cjy_q & ~cjx_q;

    fxcmul_negsat #(.DW(DW)) u_conj_x (.din(xi_q), .neg(negx), .dout(xi_c));
    fxcmul_negsat #(.DW(DW)) u_conj_y (.din(yi_q), .neg(negy), .dout(yi_c));

    // Partial products: index bit1 picks X part, bit0 picks Y part
    logic [DW-1:0] aop [NPROD];
    logic [DW-1:0] bop [NPROD];
    logic [PW-1:0] prod_q [NPROD];

    generate
        for (genvar g = 0; g < NPROD; g++) begin : g_prod
            assign aop[g] = (g / 2 == 1) ? xi_c : xr_q;
            assign bop[g] = (g % 2 == 1) ? yi_c : yr_q;
            fxcmul_pmul #(.DW(DW)) u_pmul (
                .clk   (clk),
                .rst_n (rst_n),
                .a     (aop[g]),
                .b     (bop[g]),
                .p_q   (prod_q[g])
            );
        end
    endgenerate

    // Add/subtract stage: real = rr - ii, imaginary = ri + ir
    logic [SW-1:0] sum_re_q, sum_im_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_re_q <= '0;
            sum_im_q <= '0;
        end else begin
            sum_re_q <= {prod_q[0][PW-1], prod_q[0]} - {prod_q[3][PW-1], prod_q[3]};
            sum_im_q <= {prod_q[1][PW-1], prod_q[1]} + {prod_q[2][PW-1], prod_q[2]};
        end
    end

    // Rounding and shift for both components
    logic [SW-1:0] post_re, post_im;

    fxcmul_post #(.DW(DW)) u_post_re (
        .sum(sum_re_q), .rnd(rnd_p[NSTAGE-1]), .shift(sh_p[NSTAGE-1]), .res(post_re)
    );
    fxcmul_post #(.DW(DW)) u_post_im (
        .sum(sum_im_q), .rnd(rnd_p[NSTAGE-1]), .shift(sh_p[NSTAGE-1]), .res(post_im)
    );

    // Output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_re    <= '0;
            out_im    <= '0;
        end else begin
            out_valid <= vld_p[NSTAGE-1];
            out_re    <= post_re;
            out_im    <= post_im;
        end
    end

    // Shift of the sum stage, brought out for the bound checker
    logic [1:0] sh_sum;
    assign sh_sum = sh_p[NSTAGE-1];
endmodule

// File: rtl/fxcmul_chk.sv
// Module: fxcmul_chk
// Property checker for fxcmul, attached with bind below.
// Assumes: synchronous active-low reset; watches ports and stage registers.
module fxcmul_chk #(
    parameter int unsigned DW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            x_load,
    input logic            y_load,
    input logic            out_valid,
    input logic [DW-1:0]   xr_q,
    input logic [DW-1:0]   xi_q,
    input logic [DW-1:0]   yr_q,
    input logic [DW-1:0]   yi_q,
    input logic [2*DW-2:0] prod_q [4],
    input logic [2*DW-1:0] sum_re_q,
    input logic [2*DW-1:0] sum_im_q,
    input logic [1:0]      sh_sum,
    input logic [2*DW-1:0] out_re,
    input logic [2*DW-1:0] out_im
);
    localparam int unsigned PW = 2 * DW - 1;
    localparam logic [PW-1:0] PMIN = {1'b1, {(PW-1){1'b0}}};

    // Edges since reset release, saturating, to keep $past inside that window
    logic [2:0] since_rst;
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 3'd4)
            since_rst <= since_rst + 1'b1;
    end

    // R12: a start flag reappears as out_valid four sampling edges later
    a_r12_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd4) |-> (out_valid == $past(x_load | y_load, 4)));

    // R2: X register holds when not loaded
    a_r2_x_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !x_load |=> ($stable(xr_q) && $stable(xi_q)));

    // R2: Y register holds when not loaded
    a_r2_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !y_load |=> ($stable(yr_q) && $stable(yi_q)));

    // R4: the trap keeps every partial product off the unrepresentable code
    a_r4_no_min_product: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_q[0] != PMIN) && (prod_q[1] != PMIN) &&
        (prod_q[2] != PMIN) && (prod_q[3] != PMIN));

    // R9: with no shift, the lower half of each sum reaches the output unchanged
    a_r9_low_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_sum == 2'b00) |=>
        ((out_re[DW-1:0] == $past(sum_re_q[DW-1:0])) &&
         (out_im[DW-1:0] == $past(sum_im_q[DW-1:0]))));
endmodule

bind fxcmul fxcmul_chk #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .x_load    (x_load),
    .y_load    (y_load),
    .out_valid (out_valid),
    .xr_q      (xr_q),
    .xi_q      (xi_q),
    .yr_q      (yr_q),
    .yi_q      (yi_q),
    .prod_q    (prod_q),
    .sum_re_q  (sum_re_q),
    .sum_im_q  (sum_im_q),
    .sh_sum    (sh_sum),
    .out_re    (out_re),
    .out_im    (out_im)
);

// File: tb/fxcmul_test.sv
`timescale 1ns/1ps
// Bench: scoreboard for fxcmul. A driver task predicts each result from the
// requirements and queues it with its due cycle; a monitor compares results.
module fxcmul_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        x_load = 1'b0, y_load = 1'b0;
    logic [15:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0;
    logic        conj_x = 1'b0, conj_y = 1'b0, round_en = 1'b0;
    logic [1:0]  shift_sel = 2'b00;
    logic        out_valid;
    logic [31:0] out_re, out_im;

    always #4 clk = ~clk;

    fxcmul uut (
        .clk(clk), .rst_n(rst_n), .x_load(x_load), .y_load(y_load),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
        .conj_x(conj_x), .conj_y(conj_y), .round_en(round_en),
        .shift_sel(shift_sel), .out_valid(out_valid),
        .out_re(out_re), .out_im(out_im)
    );

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;

    logic [31:0] q_re [$];
    logic [31:0] q_im [$];
    int          q_due [$];
    string       q_tag [$];

    // Model of the held operand registers
    int hx_re = 0, hx_im = 0, hy_re = 0, hy_im = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int negsat(input int v);
        return (v == -32768) ? 32767 : -v;
    endfunction

    function automatic longint pmul(input int a, input int b);
        if (a == -32768 && b == -32768) return (longint'(1) <<< 30) - 1;
        return longint'(a) * longint'(b);
    endfunction

    function automatic logic [31:0] post(input logic [31:0] s, input bit rnd,
                                         input logic [1:0] sh);
        logic [31:0] t;
        logic [31:0] r;
        logic signed [31:0] rs;
        t = s + 32'h0000_8000;
        r = rnd ? {t[31:16], s[15:0]} : s;
        rs = r;
        case (sh)
            2'b01:   return 32'(rs >>> 1);
            2'b10:   return r << 2;
            2'b11:   return r << 1;
            default: return r;
        endcase
    endfunction

    function automatic int rnd16();
        logic signed [15:0] t;
        t = 16'($urandom);
        return int'(t);
    endfunction

    // Driver: drive one cycle; if it starts an operation, queue the prediction
    task automatic apply(input int xr, input int xi, input int yr, input int yi,
                         input bit xl, input bit yl, input bit cx, input bit cy,
                         input bit rnd, input logic [1:0] sh, input string tag);
        int ex_im, ey_im;
        longint re, im;
        @(negedge clk);
        x_re = 16'(xr); x_im = 16'(xi); y_re = 16'(yr); y_im = 16'(yi);
        x_load = xl; y_load = yl; conj_x = cx; conj_y = cy;
        round_en = rnd; shift_sel = sh;
        if (xl) begin hx_re = xr; hx_im = xi; end
        if (yl) begin hy_re = yr; hy_im = yi; end
        if (xl || yl) begin
            ex_im = (cx && !cy) ? negsat(hx_im) : hx_im;
            ey_im = (cy && !cx) ? negsat(hy_im) : hy_im;
            re = pmul(hx_re, hy_re) - pmul(ex_im, ey_im);
            im = pmul(hx_re, ey_im) + pmul(ex_im, hy_re);
            q_re.push_back(post(32'(re), rnd, sh));
            q_im.push_back(post(32'(im), rnd, sh));
            q_due.push_back(cyc + 4);
            q_tag.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) apply(0, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, "R12");
    endtask

    // Monitor: every valid result must be due now and match the prediction
    always @(negedge clk) begin
        if (mon_on && out_valid) begin
            if (q_due.size() == 0) begin
                check(1'b0, "R12", "unexpected valid", 32'd1, 32'd0);
            end else begin
                logic [31:0] er, ei;
                int due;
                string tg;
                er = q_re.pop_front(); ei = q_im.pop_front();
                due = q_due.pop_front(); tg = q_tag.pop_front();
                check(due == cyc, "R12", "latency cycle", 32'(cyc), 32'(due));
                check(out_re == er, tg, "real", out_re, er);
                check(out_im == ei, tg, "imag", out_im, ei);
            end
        end else if (mon_on && q_due.size() != 0 && q_due[0] < cyc) begin
            check(1'b0, "R12", "missing valid", 32'd0, 32'd1);
            void'(q_re.pop_front()); void'(q_im.pop_front());
            void'(q_due.pop_front()); void'(q_tag.pop_front());
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL R11 watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(out_valid == 1'b0, "R1", "out_valid", 32'(out_valid), 32'd0);
        check(out_re == 32'd0, "R1", "out_re", out_re, 32'd0);
        check(out_im == 32'd0, "R1", "out_im", out_im, 32'd0);
        mon_on = 1'b1;

        // R3: fixed products
        apply(16384, 8192, 16384, -16384, 1, 1, 0, 0, 0, 2'b00, "R3");
        apply(32767, 32767, 32767, -32768, 1, 1, 0, 0, 0, 2'b00, "R3");
        apply(-1, 1, 12345, -23456, 1, 1, 0, 0, 0, 2'b00, "R3");
        idle(2);
        // R11: back-to-back random stream
        for (int i = 0; i < 30; i++)
            apply(rnd16(), rnd16(), rnd16(), rnd16(), 1, 1, 0, 0, 0, 2'b00, "R11");
        // R4: minus one squared in all products and in one product
        apply(-32768, -32768, -32768, -32768, 1, 1, 0, 0, 0, 2'b00, "R4");
        apply(-32768, 0, -32768, 0, 1, 1, 0, 0, 0, 2'b00, "R4");
        apply(0, -32768, 0, -32768, 1, 1, 0, 0, 0, 2'b00, "R4");
        // R5, R6, R7: conjugation controls
        apply(20000, -7000, 3000, 15000, 1, 1, 1, 0, 0, 2'b00, "R5");
        apply(20000, -7000, 3000, 15000, 1, 1, 0, 1, 0, 2'b00, "R6");
        apply(20000, -7000, 3000, 15000, 1, 1, 1, 1, 0, 2'b00, "R7");
        // R8: conjugating a -1 imaginary part
        apply(16384, -32768, 16384, 8192, 1, 1, 1, 0, 0, 2'b00, "R8");
        apply(-16384, 4096, 0, -32768, 1, 1, 0, 1, 0, 2'b00, "R8");
        idle(1);
        // R9: rounding
        for (int i = 0; i < 12; i++)
            apply(rnd16(), rnd16(), rnd16(), rnd16(), 1, 1, 0, 0, 1, 2'b00, "R9");
        apply(32767, 0, 32767, 0, 1, 1, 0, 0, 1, 2'b00, "R9");
        // R10: each shift code, with and without rounding
        for (int s = 0; s < 4; s++)
            for (int i = 0; i < 5; i++)
                apply(rnd16(), rnd16(), rnd16(), rnd16(), 1, 1, 0, 0, i[0], 2'(s), "R10");
        apply(-32768, -32768, -32768, -32768, 1, 1, 0, 0, 0, 2'b11, "R10");
        // R2: X held while Y loads, then Y held while X loads
        apply(12000, -9000, 1000, 2000, 1, 1, 0, 0, 0, 2'b00, "R2");
        for (int i = 0; i < 5; i++)
            apply(rnd16(), rnd16(), rnd16(), rnd16(), 0, 1, 0, 0, 0, 2'b00, "R2");
        for (int i = 0; i < 5; i++)
            apply(rnd16(), rnd16(), rnd16(), rnd16(), 1, 0, i[0], 0, 0, 2'b00, "R2");
        // R12: gaps between operations
        idle(3);
        apply(5000, 6000, 7000, 8000, 1, 1, 0, 0, 0, 2'b00, "R12");
        idle(1);
        apply(-5000, 6000, 7000, -8000, 1, 1, 0, 0, 1, 2'b01, "R12");
        idle(2);
        // R11: mixed random stream with random controls and enables
        for (int i = 0; i < 120; i++) begin
            logic [3:0] c;
            c = 4'($urandom);
            apply(rnd16(), rnd16(), rnd16(), rnd16(), c[0] | c[3], c[1] | c[3],
                  c[2], c[3], c[1], 2'($urandom), "R11");
        end
        idle(8);
        check(q_due.size() == 0, "R12", "queue drained", 32'(q_due.size()), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule